// File: doc/BRIEF.md
# Sleep and Wake Power Sequencer

This block controls how a chip goes into a low-power sleep state and comes back out. It runs from a 32.768 kHz timebase, so one clock period (about 30.5 µs) is the unit of every delay it makes. An internal request puts the system to sleep in a fixed order. First the active-low system reset output is pulled low. A short, fixed time later the supply enable output is dropped.

While asleep, the block watches a set of wake lines. Each line has its own enable bit. A line wakes the system only when it is enabled and held high for a minimum number of consecutive ticks while the battery-fault input reads healthy. A wake raises the supply enable after a short delay, then waits a long settle interval for the core supply to become stable. The reset is released only when that interval has expired and the battery is still healthy. A status output reports which wake line ended the last sleep.

Top module: `sws_seq`

## Requirements
- R1: After reset, and in the running state, `rst_out_n` is 1, `pwr_en` is 1 and `sleep_st` is 0. `wake_src` is 0 after reset.
- R2: When `sleep_req` is seen high at a clock edge in the running state, `rst_out_n` goes low at that edge and `pwr_en` stays high. `pwr_en` goes low OFF_TICKS (2) edges later. `sleep_st` goes high one edge after that.
- R3: `pwr_en` is never low while `rst_out_n` is high.
- R4: A wake is accepted when an enabled wake line is sampled high at QUAL_TICKS (3) consecutive edges while asleep. `sleep_st` falls at the third of those edges. `pwr_en` rises ON_TICKS (1) edge later, which is the fourth edge after the line was raised.
- R5: A wake line that drops before it has been sampled high QUAL_TICKS times in a row loses its progress and does not wake the block.
- R6: A wake line whose bit in `wake_en` is 0 has no effect, however long it is held.
- R7: While `batt_flt_n` is 0, no wake is accepted. Qualification starts again from zero once `batt_flt_n` returns to 1.
- R8: With `batt_flt_n` high, `rst_out_n` rises SETTLE_TICKS (328) edges after `pwr_en` rises. The block returns to the running state one edge later.
- R9: If `batt_flt_n` is 0 when the settle interval expires, `rst_out_n` stays low. It rises at the first edge that samples `batt_flt_n` high.
- R10: `wake_src` takes the index of the line that ended sleep. When several lines qualify at the same edge, the lowest index wins. The value holds until the next accepted wake.
- R11: `sleep_req` has no effect in any state other than the running state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz timebase clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| sleep_req | input | 1 | Internal request to enter sleep |
| wake_en | input | N_WAKE | Per-line wake enable |
| wake_in | input | N_WAKE | Wake source lines, active high |
| batt_flt_n | input | 1 | Battery fault, active low (1 = healthy) |
| rst_out_n | output | 1 | System reset, active low |
| pwr_en | output | 1 | Core supply enable |
| sleep_st | output | 1 | High while in the sleep state |
| wake_src | output | $clog2(N_WAKE) | Index of the line that ended the last sleep |

## Verification
The assertions assume three things about the inputs: all inputs change only between timebase edges, `wake_en` is stable while a wake line is being qualified, and `batt_flt_n` is a settled digital level. The stimulus meets these by driving every input one nanosecond after a rising edge. Enable masks are chosen before a trial begins and are not changed while a line is held. Random masks and line patterns from a fixed seed are mixed with directed cases: short pulses, disabled lines, battery faults during sleep and during settle, and a request that arrives during settle.

// File: rtl/sws_pkg.sv
package sws_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_ASSERT_RST,
    ST_PWR_OFF,
    ST_SLEEP,
    ST_PWR_UP,
    ST_SETTLE,
    ST_RELEASE
  } sws_state_e;

  // Number of ticks a timed state lasts before it may be left.
  function automatic int unsigned dwell_limit(sws_state_e st,
                                              int unsigned off_t,
                                              int unsigned on_t,
                                              int unsigned settle_t);
    case (st)
      ST_ASSERT_RST: return off_t;
      ST_PWR_UP:     return on_t;
      ST_SETTLE:     return settle_t;
      default:       return 1;
    endcase
  endfunction

  // Reset output is high only in the states where the core runs.
  function automatic logic rst_level(sws_state_e st);
    return (st == ST_RUN) || (st == ST_RELEASE);
  endfunction

  // Supply is off from the power-off step until the power-up delay ends.
  function automatic logic pwr_level(sws_state_e st);
    return !((st == ST_PWR_OFF) || (st == ST_SLEEP) || (st == ST_PWR_UP));
  endfunction

endpackage

// File: rtl/sws_tick_timer.sv
module sws_tick_timer #(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clr)            cnt <= '0;
    else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/sws_wake_qual.sv
module sws_wake_qual #(
  parameter int unsigned N    = 16,
  parameter int unsigned QUAL = 3,
  parameter int unsigned IW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic [N-1:0]  wake_in,
  input  logic [N-1:0]  wake_en,
  output logic          hit,
  output logic [IW-1:0] hit_idx
);

  localparam int unsigned CW = (QUAL > 1) ? $clog2(QUAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(QUAL - 1);

  logic [N-1:0] line_ok;

  for (genvar g = 0; g < N; g++) begin : g_line
    logic          act;
    logic [CW-1:0] run_q;

    assign act        = arm && wake_in[g] && wake_en[g];
    assign line_ok[g] = act && (run_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             run_q <= '0;
      else if (!act)          run_q <= '0;
      else if (run_q != LAST) run_q <= run_q + 1'b1;
    end
  end

  assign hit = |line_ok;

  // Lowest index wins: scan from the top down so the last match is the smallest.
  always_comb begin
    hit_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (line_ok[i]) hit_idx = IW'(i);
    end
  end

endmodule

// File: rtl/sws_seq.sv
module sws_seq
  import sws_pkg::*;
#(
  parameter int unsigned N_WAKE       = 16,
  parameter int unsigned QUAL_TICKS   = 3,
  parameter int unsigned OFF_TICKS    = 2,
  parameter int unsigned ON_TICKS     = 1,
  parameter int unsigned SETTLE_TICKS = 328,
  localparam int unsigned IW = (N_WAKE > 1) ? $clog2(N_WAKE) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_req,
  input  logic [N_WAKE-1:0] wake_en,
  input  logic [N_WAKE-1:0] wake_in,
  input  logic              batt_flt_n,
  output logic              rst_out_n,
  output logic              pwr_en,
  output logic              sleep_st,
  output logic [IW-1:0]     wake_src
);

  localparam int unsigned TW = $clog2(SETTLE_TICKS + OFF_TICKS + ON_TICKS + 2);

  sws_state_e    state_q, state_d;
  logic [TW-1:0] tmr_cnt;
  logic          tmr_clr;
  logic          dwell_done;

  // Named internal events, also used by the checker.
  logic          sleep_go;
  logic          wake_arm;
  logic          wake_hit;
  logic [IW-1:0] hit_idx;
  logic          settle_done;
  logic          rel_ok;

  assign dwell_done  = tmr_cnt >= TW'(dwell_limit(state_q, OFF_TICKS, ON_TICKS, SETTLE_TICKS) - 1);
  assign sleep_go    = (state_q == ST_RUN) && sleep_req;
  assign wake_arm    = (state_q == ST_SLEEP) && batt_flt_n;
  assign settle_done = (state_q == ST_SETTLE) && dwell_done;
  assign rel_ok      = settle_done && batt_flt_n;

  sws_wake_qual #(
    .N    (N_WAKE),
    .QUAL (QUAL_TICKS),
    .IW   (IW)
  ) u_qual (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (wake_arm),
    .wake_in (wake_in),
    .wake_en (wake_en),
    .hit     (wake_hit),
    .hit_idx (hit_idx)
  );

  sws_tick_timer #(.W(TW)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .cnt   (tmr_cnt)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN:        if (sleep_go)   state_d = ST_ASSERT_RST;
      ST_ASSERT_RST: if (dwell_done) state_d = ST_PWR_OFF;
      ST_PWR_OFF:                    state_d = ST_SLEEP;
      ST_SLEEP:      if (wake_hit)   state_d = ST_PWR_UP;
      ST_PWR_UP:     if (dwell_done) state_d = ST_SETTLE;
      ST_SETTLE:     if (rel_ok)     state_d = ST_RELEASE;
      ST_RELEASE:                    state_d = ST_RUN;
      default:                       state_d = ST_RUN;
    endcase
  end

  assign tmr_clr = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             wake_src <= '0;
    else if (wake_hit && state_q == ST_SLEEP) wake_src <= hit_idx;
  end

  assign rst_out_n = rst_level(state_q);
  assign pwr_en    = pwr_level(state_q);
  assign sleep_st  = (state_q == ST_SLEEP);

endmodule

// File: rtl/sws_chk.sv
module sws_chk #(
  parameter int unsigned N  = 16,
  parameter int unsigned IW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          batt_flt_n,
  input logic [N-1:0]  wake_en,
  input logic          rst_out_n,
  input logic          pwr_en,
  input logic          sleep_st,
  input logic [IW-1:0] wake_src,
  input logic          wake_hit,
  input logic [IW-1:0] hit_idx
);

  // R3
  pwr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |-> !rst_out_n);

  // R2
  rst_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_out_n) |-> pwr_en);

  // R2
  pwr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_en) |-> ($past(!rst_out_n) && $past(!rst_out_n, 2)));

  // R4
  pwr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_en) |-> (!rst_out_n && !sleep_st));

  // R9
  batt_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out_n) |-> $past(batt_flt_n));

  // R7
  batt_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_hit && sleep_st) |-> batt_flt_n);

  // R6
  wake_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_hit |-> wake_en[hit_idx]);

  // R10
  src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wake_hit && sleep_st) |=> $stable(wake_src));

  // R10
  src_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_hit && sleep_st) |=> (wake_src == $past(hit_idx)));

endmodule

bind sws_seq sws_chk #(.N(N_WAKE), .IW(IW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .batt_flt_n (batt_flt_n),
  .wake_en    (wake_en),
  .rst_out_n  (rst_out_n),
  .pwr_en     (pwr_en),
  .sleep_st   (sleep_st),
  .wake_src   (wake_src),
  .wake_hit   (wake_hit),
  .hit_idx    (hit_idx)
);

// File: tb/sim_sws_seq.sv
`timescale 1ns/1ps
module sim_sws_seq;

  localparam int N      = 16;
  localparam int IW     = 4;
  localparam int SETTLE = 328;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sleep_req;
  logic [N-1:0]  wake_en;
  logic [N-1:0]  wake_in;
  logic          batt_flt_n;
  logic          rst_out_n;
  logic          pwr_en;
  logic          sleep_st;
  logic [IW-1:0] wake_src;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  sws_seq u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep_req  (sleep_req),
    .wake_en    (wake_en),
    .wake_in    (wake_in),
    .batt_flt_n (batt_flt_n),
    .rst_out_n  (rst_out_n),
    .pwr_en     (pwr_en),
    .sleep_st   (sleep_st),
    .wake_src   (wake_src)
  );

  // Expected winner: lowest index among enabled, raised lines; -1 if none.
  function automatic int pick_low(logic [N-1:0] en, logic [N-1:0] lines);
    for (int i = 0; i < N; i++) if (en[i] && lines[i]) return i;
    return -1;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic enter_sleep();
    sleep_req = 1'b1;
    step();
    sleep_req = 1'b0;
    check("R2 rst low at request edge", rst_out_n, 0);
    check("R2 pwr still high", pwr_en, 1);
    step();
    check("R2 pwr high one tick in", pwr_en, 1);
    step();
    check("R2 pwr low after OFF_TICKS", pwr_en, 0);
    check("R3 rst low while pwr low", rst_out_n, 0);
    step();
    check("R2 asleep", sleep_st, 1);
  endtask

  task automatic still_asleep(string tag);
    check(tag, {sleep_st, pwr_en, rst_out_n}, 3'b100);
  endtask

  // Called in the cycle where the qualifying condition was just made true.
  task automatic finish_wake(int exp_idx, bit batt_hold);
    step(3);
    check("R4 sleep left at third sample", sleep_st, 0);
    check("R4 pwr still low in power-up", pwr_en, 0);
    step();
    check("R4 pwr rises at fourth edge", pwr_en, 1);
    wake_in = '0;
    if (batt_hold) batt_flt_n = 1'b0;
    step(SETTLE - 1);
    check("R8 rst low before settle end", rst_out_n, 0);
    step();
    if (batt_hold) begin
      check("R9 rst held by battery fault", rst_out_n, 0);
      step(5);
      check("R9 rst still held", rst_out_n, 0);
      batt_flt_n = 1'b1;
      step();
      check("R9 rst released once battery ok", rst_out_n, 1);
    end else begin
      check("R8 rst released at settle end", rst_out_n, 1);
    end
    check("R10 wake source index", wake_src, exp_idx);
    step();
    check("R1 running state", {rst_out_n, pwr_en, sleep_st}, 3'b110);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    rst_n = 1'b0; sleep_req = 1'b0; wake_en = '0; wake_in = '0; batt_flt_n = 1'b1;
    step(3);
    rst_n = 1'b1;
    step();
    check("R1 reset outputs", {rst_out_n, pwr_en, sleep_st}, 3'b110);
    check("R1 reset wake_src", wake_src, 0);

    // Basic wake on line 5.
    wake_en = 16'h0020;
    enter_sleep();
    wake_in[5] = 1'b1;
    finish_wake(5, 1'b0);

    // R5: short pulses lose their progress.
    wake_en = 16'h0004;
    enter_sleep();
    wake_in[2] = 1'b1; step(2); wake_in[2] = 1'b0; step();
    wake_in[2] = 1'b1; step(2); wake_in[2] = 1'b0; step(2);
    still_asleep("R5 short pulses ignored");
    wake_in[2] = 1'b1;
    finish_wake(2, 1'b0);

    // R6: disabled line ignored.
    wake_en = 16'h0001;
    enter_sleep();
    wake_in[9] = 1'b1; step(6);
    still_asleep("R6 disabled line ignored");
    wake_in = '0;
    wake_in[0] = 1'b1;
    finish_wake(0, 1'b0);

    // R7: battery fault blocks wake, qualification restarts.
    wake_en = 16'h0040;
    enter_sleep();
    batt_flt_n = 1'b0;
    wake_in[6] = 1'b1; step(6);
    still_asleep("R7 battery fault blocks wake");
    batt_flt_n = 1'b1;
    finish_wake(6, 1'b0);

    // R9: battery fault at settle expiry holds reset.
    wake_en = 16'h8000;
    enter_sleep();
    wake_in[15] = 1'b1;
    finish_wake(15, 1'b1);

    // R10: two lines qualify together, lowest wins.
    wake_en = 16'h0808;
    enter_sleep();
    wake_in = 16'h0808;
    finish_wake(3, 1'b0);

    // R11: request during settle has no effect.
    wake_en = 16'h0002;
    enter_sleep();
    wake_in[1] = 1'b1;
    step(4);
    wake_in = '0;
    step(100);
    sleep_req = 1'b1; step(2); sleep_req = 1'b0;
    step(SETTLE - 103);
    check("R11 settle unaffected by request", rst_out_n, 0);
    step();
    check("R11 release on time", rst_out_n, 1);
    step(3);
    check("R11 no new sleep entered", {rst_out_n, pwr_en}, 2'b11);

    // Random trials.
    for (int t = 0; t < 14; t++) begin
      logic [N-1:0] msk;
      logic [N-1:0] lines;
      int           exp;
      msk   = N'($urandom) | (N'(1) << ($urandom % N));
      lines = N'($urandom) & N'($urandom);
      exp   = pick_low(msk, lines);
      wake_en = msk;
      enter_sleep();
      wake_in = lines;
      if (exp >= 0) begin
        finish_wake(exp, 1'b0);
      end else begin
        step(5);
        still_asleep("R6 random disabled lines ignored");
        wake_in = '0;
        exp = pick_low(msk, msk);
        wake_in[exp] = 1'b1;
        finish_wake(exp, 1'b0);
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule